// File: doc/BRIEF.md
# Strobe-Edge Watchdog Timer

This block checks that a processor is still running. The processor must pull a strobe line low at regular intervals. Each high-to-low transition of the strobe restarts a tick counter. A millisecond tick input drives that counter. If the counter reaches the selected period before the next falling edge, the block raises a timeout request for one clock cycle. A downstream reset pulse generator uses that request to reset the processor. The generator's reset-active signal comes back into this block. While it is high, the timer is held at zero and the strobe is ignored.

The strobe is asynchronous to the clock, and a pulse may be far shorter than one clock period. A capture flag catches the edge. The inverted strobe clocks this flag, so no clock is needed to set it. A synchronizer then carries the flag into the clock domain, and a registered handshake clears it. A two-bit select chooses one of three periods, and code 3 acts like code 2. The watchdog has no disable input.

The controller has three states:
- `WD_HOLD`: the counter is cleared. This is the state during chip reset and while reset is active.
- `WD_RUN`: the counter advances on each tick.
- `WD_FIRE`: the one cycle in which the request is driven.

The transitions are:
- **release** (`WD_HOLD` to `WD_RUN`): reset-active is low.
- **kick** (`WD_RUN` to `WD_RUN`, counter cleared): a captured falling edge arrives.
- **expire** (`WD_RUN` to `WD_FIRE`): a tick arrives with the count at the period minus one and no edge in the same cycle.
- **rearm** (`WD_FIRE` to `WD_RUN`, counter at zero): always taken, one cycle after expire.
- **hold** (any state to `WD_HOLD`): reset-active is high. This transition has priority over all others.

Top module: `strobe_wdt`

## Requirements
- R1: With delay select 0, a timeout request is raised exactly PERIOD_SHORT ticks (default 150) after the last restart. The request appears in the cycle after the clock edge that samples the final tick.
- R2: With delay select 1, the request follows exactly PERIOD_MID ticks (default 610) after the last restart.
- R3: With delay select 2, and also with code 3, the request follows exactly PERIOD_LONG ticks (default 1200) after the last restart.
- R4: A falling strobe edge while the timer runs restarts the count from zero. The next request then needs a full period of ticks after that edge.
- R5: A rising strobe edge does not restart the timer, and neither does a strobe held at a steady level.
- R6: A low-going strobe pulse of 1 ns, much shorter than the clock period, is still caught and restarts the timer. Repeated pulses spaced within the period prevent any request.
- R7: While reset_active is high, no request is raised, the count is held at zero and falling strobe edges have no effect. After release, the first request follows a full period later.
- R8: The timeout request lasts exactly one cycle. Counting then restarts from zero, so a timer that gets no strobe fires again one full period later.
- R9: While rst_n is low and afterwards, until a full period has elapsed after reset_active goes low, timeout_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| strobe_async | input | 1 | Processor strobe, asynchronous; a falling edge restarts the timer |
| reset_active | input | 1 | High while the downstream reset is asserted |
| delay_sel | input | 2 | Period select: 0 short, 1 mid, 2 or 3 long |
| timeout_req | output | 1 | One-cycle request to the reset pulse generator |

## Verification
The bound checker enforces several rules on every cycle:
- A tick that completes the period in the run state, with no edge present, is followed by a request (R1).
- A request is always caused by a tick.
- Reset-active suppresses the request in the next cycle (R7).
- A request never lasts two cycles (R8).
- A captured edge in the run state leaves the counter at zero (R4).

Other behaviours depend on sequences and can only be shown by the bench's scenarios:
- the exact period length for each select code;
- that rising edges and steady levels are ignored;
- that 1 ns pulses are captured across the asynchronous boundary;
- that edges given during reset have no lasting effect.

The bench checks these against a tick-counting model.

// File: rtl/strobe_wdt_pkg.sv
`timescale 1ns/1ps
package strobe_wdt_pkg;

    typedef enum logic [1:0] {
        WD_HOLD = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_t;

    // Map the two-bit select onto one of three periods; code 3 aliases code 2.
    function automatic int unsigned pick_period(
        input logic [1:0]  sel,
        input int unsigned p_short,
        input int unsigned p_mid,
        input int unsigned p_long
    );
        unique case (sel)
            2'd0:    return p_short;
            2'd1:    return p_mid;
            default: return p_long;
        endcase
    endfunction

endpackage

// File: rtl/strobe_wdt_edge.sv
`timescale 1ns/1ps
// Catches a falling strobe edge of any width and delivers one clock-domain pulse.
module strobe_wdt_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_evt
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic                   strobe_inv;
    logic                   catch_flag;
    logic                   clr_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;

    assign strobe_inv = ~strobe_async;

    // The inverted strobe clocks the flag; the clear comes back from the clock domain.
    always_ff @(posedge strobe_inv or posedge clr_q) begin
        if (clr_q) begin
            catch_flag <= 1'b0;
        end else begin
            catch_flag <= 1'b1;
        end
    end

    // Synchronizer chain, depth set by parameter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= catch_flag;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // The clear is held while the synchronized flag is high, and stays high during chip reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q  <= 1'b1;
            seen_q <= 1'b0;
        end else begin
            clr_q  <= sync_q[TOP];
            seen_q <= sync_q[TOP];
        end
    end

    assign strobe_evt = sync_q[TOP] & ~seen_q;

endmodule

// File: rtl/strobe_wdt_limit.sv
`timescale 1ns/1ps
// Turns the delay select into a terminal tick count.
module strobe_wdt_limit
    import strobe_wdt_pkg::*;
#(
    parameter int unsigned PERIOD_SHORT = 150,
    parameter int unsigned PERIOD_MID   = 610,
    parameter int unsigned PERIOD_LONG  = 1200,
    parameter int unsigned CNT_W        = 11
) (
    input  logic [1:0]       delay_sel,
    output logic [CNT_W-1:0] limit
);
    int unsigned chosen;

    always_comb begin
        chosen = pick_period(delay_sel, PERIOD_SHORT, PERIOD_MID, PERIOD_LONG);
        limit  = CNT_W'(chosen);
    end

endmodule

// File: rtl/strobe_wdt_counter.sv
`timescale 1ns/1ps
// Tick counter. It flags the tick that completes the period.
module strobe_wdt_counter #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             ms_tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] last_val;

    assign last_val = limit - CNT_W'(1);
    // The >= compare lets a shortened period still expire if the count has passed the new limit.
    assign hit      = ms_tick && (count >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/strobe_wdt_fsm.sv
`timescale 1ns/1ps
// Controller: hold, run, fire.
module strobe_wdt_fsm
    import strobe_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_active,
    input  logic strobe_evt,
    input  logic ms_tick,
    input  logic hit,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic in_run,
    output logic timeout_req
);
    wd_state_t state_q;
    wd_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        if (reset_active) begin
            state_d = WD_HOLD;                       // hold
        end else begin
            unique case (state_q)
                WD_HOLD: state_d = WD_RUN;           // release
                WD_RUN: begin
                    if (strobe_evt) begin
                        state_d = WD_RUN;            // kick
                    end else if (hit) begin
                        state_d = WD_FIRE;           // expire
                    end
                end
                WD_FIRE: state_d = WD_RUN;           // rearm
                default: state_d = WD_HOLD;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        in_run      = 1'b0;
        timeout_req = 1'b0;
        unique case (state_q)
            WD_HOLD: cnt_clr = 1'b1;
            WD_RUN: begin
                in_run  = 1'b1;
                cnt_clr = strobe_evt | reset_active;
                cnt_inc = ms_tick & ~strobe_evt & ~reset_active & ~hit;
            end
            WD_FIRE: begin
                cnt_clr     = 1'b1;
                timeout_req = 1'b1;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/strobe_wdt.sv
`timescale 1ns/1ps
module strobe_wdt #(
    parameter int unsigned PERIOD_SHORT = 150,
    parameter int unsigned PERIOD_MID   = 610,
    parameter int unsigned PERIOD_LONG  = 1200,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       strobe_async,
    input  logic       reset_active,
    input  logic [1:0] delay_sel,
    output logic       timeout_req
);
    localparam int unsigned MAX_A  = (PERIOD_SHORT > PERIOD_MID) ? PERIOD_SHORT : PERIOD_MID;
    localparam int unsigned MAX_P  = (MAX_A > PERIOD_LONG) ? MAX_A : PERIOD_LONG;
    localparam int unsigned CNT_W  = $clog2(MAX_P + 1);

    logic             strobe_evt;
    logic [CNT_W-1:0] period_limit;
    logic [CNT_W-1:0] tick_count;
    logic             hit;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             in_run;

    strobe_wdt_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (strobe_async),
        .strobe_evt   (strobe_evt)
    );

    strobe_wdt_limit #(
        .PERIOD_SHORT (PERIOD_SHORT),
        .PERIOD_MID   (PERIOD_MID),
        .PERIOD_LONG  (PERIOD_LONG),
        .CNT_W        (CNT_W)
    ) u_limit (
        .delay_sel (delay_sel),
        .limit     (period_limit)
    );

    strobe_wdt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .ms_tick (ms_tick),
        .limit   (period_limit),
        .count   (tick_count),
        .hit     (hit)
    );

    strobe_wdt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_active (reset_active),
        .strobe_evt   (strobe_evt),
        .ms_tick      (ms_tick),
        .hit          (hit),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .in_run       (in_run),
        .timeout_req  (timeout_req)
    );

endmodule

// File: rtl/strobe_wdt_chk.sv
`timescale 1ns/1ps
module strobe_wdt_chk #(
    parameter int unsigned CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ms_tick,
    input logic             reset_active,
    input logic             timeout_req,
    input logic             strobe_evt,
    input logic             in_run,
    input logic             hit,
    input logic [CNT_W-1:0] count
);
    // R1: a completing tick in the run state, with no edge and no reset, leads to a request.
    assert_expire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && hit && !strobe_evt && !reset_active) |=> timeout_req);

    // R1: a request only ever rises after a tick.
    assert_fire_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_req) |-> $past(ms_tick));

    // R4: a captured edge in the run state clears the counter.
    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && strobe_evt) |=> (count == '0));

    // R7: reset-active suppresses the request.
    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> !timeout_req);

    // R8: the request is one cycle wide.
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |=> !timeout_req);

endmodule

bind strobe_wdt strobe_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .reset_active (reset_active),
    .timeout_req  (timeout_req),
    .strobe_evt   (strobe_evt),
    .in_run       (in_run),
    .hit          (hit),
    .count        (tick_count)
);

// File: tb/strobe_wdt_tb.sv
`timescale 1ns/1ps
module strobe_wdt_tb;
    localparam int PA       = 15;
    localparam int PB       = 31;
    localparam int PC       = 52;
    localparam int TICK_DIV = 8;

    logic       clk          = 1'b0;
    logic       rst_n        = 1'b0;
    logic       ms_tick      = 1'b0;
    logic       strobe_async = 1'b1;
    logic       reset_active = 1'b1;
    logic [1:0] delay_sel    = 2'd0;
    logic       timeout_req;

    int    checks = 0;
    int    errors = 0;
    int    phase  = 0;
    int    tk     = 0;
    int    fires  = 0;
    bit    exp_fire = 1'b0;
    string req = "R9";

    strobe_wdt #(
        .PERIOD_SHORT (PA),
        .PERIOD_MID   (PB),
        .PERIOD_LONG  (PC)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .strobe_async (strobe_async),
        .reset_active (reset_active),
        .delay_sel    (delay_sel),
        .timeout_req  (timeout_req)
    );

    always #4 clk = ~clk;

    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'd0:    return PA;
            2'd1:    return PB;
            default: return PC;
        endcase
    endfunction

    task automatic check(input string r, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    // ops: 0 none, 1 short low pulse, 2 assert reset, 3 release, 4 level low, 5 level high
    task automatic cyc(input int op);
        @(negedge clk);
        check(req, int'(timeout_req), int'(exp_fire), "timeout_req");
        if (timeout_req) fires++;
        exp_fire = 1'b0;
        ms_tick  = (phase == 0);
        phase    = (phase + 1) % TICK_DIV;
        if (ms_tick && !reset_active && rst_n) begin
            tk++;
            if (tk >= period_of(delay_sel)) begin
                exp_fire = 1'b1;
                tk = 0;
            end
        end
        case (op)
            1: begin
                strobe_async = 1'b0;
                #1;
                strobe_async = 1'b1;
                if (!reset_active) tk = 0;
            end
            2: begin reset_active = 1'b1; tk = 0; end
            3: begin reset_active = 1'b0; tk = 0; end
            4: begin strobe_async = 1'b0; if (!reset_active) tk = 0; end
            5: strobe_async = 1'b1;
            default: ;
        endcase
    endtask

    task automatic go(input int op);
        while (phase != 1) cyc(0);
        cyc(op);
    endtask

    task automatic run_ticks(input int n);
        repeat (n * TICK_DIV) cyc(0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        void'($urandom(32'd4242));
        // R9: chip reset, then hold
        req = "R9";
        repeat (6) cyc(0);
        rst_n = 1'b1;
        repeat (40) cyc(0);
        check("R9", fires, 0, "fires during reset");

        // R1, R2, R3: each select code gives its period
        for (int s = 0; s < 4; s++) begin
            req = (s == 0) ? "R1" : (s == 1) ? "R2" : "R3";
            delay_sel = 2'(s);
            go(0);
            f0 = fires;
            go(3);
            run_ticks(period_of(2'(s)) - 1);
            check(req, fires - f0, 0, "fires before period");
            run_ticks(2);
            check(req, fires - f0, 1, "fires after period");
            go(2);
            repeat (10) cyc(0);
        end

        // R4 and R6: short pulses keep it alive, then one edge restarts
        req = "R6";
        delay_sel = 2'd0;
        go(3);
        f0 = fires;
        for (int k = 0; k < 6; k++) begin
            run_ticks(PA - 4);
            go(1);
        end
        check("R6", fires - f0, 0, "fires with pulses");
        req = "R4";
        run_ticks(PA + 2);
        check("R4", fires - f0, 1, "fires after last pulse");
        go(2);
        repeat (10) cyc(0);

        // R5: rising edge and steady levels do not restart
        req = "R5";
        go(4);
        repeat (10) cyc(0);
        f0 = fires;
        go(3);
        run_ticks(5);
        go(5);
        run_ticks(PA - 5 + 1);
        check("R5", fires - f0, 1, "fire despite rising edge");
        go(2);
        repeat (10) cyc(0);

        // R7: edges during reset ignored, no request while held
        req = "R7";
        f0 = fires;
        for (int k = 0; k < 4; k++) begin
            run_ticks(PA / 2);
            go(1);
        end
        run_ticks(4);
        check("R7", fires - f0, 0, "fires while held");
        go(3);
        run_ticks(PA + 1);
        check("R7", fires - f0, 1, "fire after release");

        // R8: keeps firing once per period without a strobe
        req = "R8";
        run_ticks(2 * PA);
        check("R8", fires - f0, 3, "repeat fires");
        go(2);
        repeat (10) cyc(0);

        // Random trials with mixed codes, pulses and reset
        for (int t = 0; t < 30; t++) begin
            req = "R4";
            delay_sel = 2'($urandom_range(0, 3));
            go(3);
            for (int j = 0; j < 3 * period_of(delay_sel); j++) begin
                int r;
                r = $urandom_range(0, 99);
                if (r < 6) go(1);
                else if (r < 7) begin go(2); go(3); end
                else repeat (TICK_DIV) cyc(0);
            end
            go(2);
            repeat (10) cyc(0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule